// File: doc/BRIEF.md
# Interrupt-Gated Bus Stall Timer

This block watches a serial bus controller for a transaction that has stopped making progress. A 14-bit up-counter advances only while the timer is enabled and the controller's pending-service flag is low. While that flag is high, the counter is held at zero. When the flag drops, counting restarts from zero, so each stall is measured from the moment software last serviced the controller.

An optional prescaler divides the counting rate by four, which makes the timeout period four times longer. When the counter rolls over from all ones, the block raises a sticky stall flag. Software clears that flag by pulsing a write-one-to-clear strobe. The flag, gated by an interrupt enable, drives a registered interrupt request. If a rollover and a clear strobe fall in the same cycle, the rollover wins. Turning the timer off zeroes the counter and the prescaler but leaves the stall flag as it is.

Top module: `bus_stall_timer`

## Requirements
- R1: Directly after a synchronous reset, `stall_flag` and `irq` are both 0.
- R2: With `tmo_en`=1, `svc_pend`=0 and `slow_sel`=0 held, `stall_flag` rises at the 16384th rising clock edge after counting starts (2^14 ticks), and not earlier.
- R3: While `svc_pend`=1 the counter is held at zero. After `svc_pend` returns to 0, a complete 16384-tick period must elapse before `stall_flag` sets, whatever had been counted before.
- R4: With `slow_sel`=1, one tick is counted every fourth clock edge, so `stall_flag` rises at the 65536th edge after counting starts.
- R5: `stall_flag` is sticky. It stays 1 until an edge where `clr_w1c`=1 and no rollover occurs, and it reads 0 after that edge.
- R6: `irq` is a register loaded on each edge with the next value of `stall_flag` ANDed with `irq_en`. It is therefore 0 on the edge after `irq_en` is seen low, and 1 on the edge after `irq_en` is seen high while the flag is set.
- R7: When a rollover and `clr_w1c`=1 occur on the same edge, `stall_flag` is 1 after that edge.
- R8: `tmo_en`=0 zeroes the counter and the prescaler, so a re-enable needs a full period. It leaves an already-set `stall_flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmo_en | input | 1 | Timer enable |
| slow_sel | input | 1 | Selects the divide-by-4 count rate |
| svc_pend | input | 1 | Controller service-pending flag; holds the counter at zero while high |
| irq_en | input | 1 | Interrupt enable |
| clr_w1c | input | 1 | Write-one-to-clear strobe for the stall flag |
| stall_flag | output | 1 | Sticky timeout flag |
| irq | output | 1 | Registered interrupt request |

## Verification
Two functions of this block can land on the same edge: the rollover that sets the stall flag, and a software clear. The bench provokes this collision by counting up to the edge just before the rollover and then raising the clear strobe for exactly that edge. The flag is judged right if it reads 1 afterwards. A clear strobe applied one edge away from any rollover must leave the flag at 0, and this serves as the contrast case.

// File: rtl/tmo_pkg.sv
package tmo_pkg;
  // Default width of the stall counter and ratio of the slow count rate.
  localparam int unsigned TMO_CNT_W_DEF = 14;
  localparam int unsigned TMO_SLOW_DIV_DEF = 4;
endpackage

// File: rtl/tmo_prescale.sv
// Tick generator: every clock when fast, every DIV-th clock when slow.
module tmo_prescale #(
  parameter int unsigned DIV = tmo_pkg::TMO_SLOW_DIV_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic slow,
  output logic tick
);
  generate
    if (DIV > 1) begin : g_div
      localparam int unsigned PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pre_q;

      always_ff @(posedge clk) begin
        if (rst || !run)      pre_q <= '0;
        else if (pre_q == LAST) pre_q <= '0;
        else                  pre_q <= pre_q + 1'b1;
      end

      assign tick = run && (!slow || (pre_q == LAST));

      // R8: a stopped timer leaves the prescaler at zero
      assert_pre_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !run |=> (pre_q == '0));
    end else begin : g_nodiv
      assign tick = run;
    end
  endgenerate
endmodule

// File: rtl/tmo_counter.sv
// Stall counter: zeroed while stopped, rollover pulse on wrap from all ones.
module tmo_counter #(
  parameter int unsigned CW = tmo_pkg::TMO_CNT_W_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic wrap
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (tick)   cnt_q <= cnt_q + 1'b1;
  end

  assign wrap = tick && (&cnt_q);

  // R3/R8: once stopped, the count restarts from zero
  assert_cnt_zero_R3: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0));
  // R2: counting never skips; a tick advances by exactly one
  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !(&cnt_q)) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/tmo_flag.sv
// Sticky stall flag with set-over-clear priority and gated interrupt register.
module tmo_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic clr,
  input  logic ie,
  output logic flag,
  output logic irq
);
  logic flag_nxt;

  assign flag_nxt = set_evt || (flag && !clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      flag <= flag_nxt;
      irq  <= flag_nxt && ie;
    end
  end

  assert_flag_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);
  assert_flag_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (clr && !set_evt) |=> !flag);
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> flag);
  assert_irq_gate_R6: assert property (@(posedge clk) disable iff (rst)
    !ie |=> !irq);
  assert_irq_flag_R6: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag);
endmodule

// File: rtl/bus_stall_timer.sv
// Top: bus stall timeout with service-flag gating and selectable slow rate.
module bus_stall_timer #(
  parameter int unsigned CNT_W    = tmo_pkg::TMO_CNT_W_DEF,
  parameter int unsigned SLOW_DIV = tmo_pkg::TMO_SLOW_DIV_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic tmo_en,
  input  logic slow_sel,
  input  logic svc_pend,
  input  logic irq_en,
  input  logic clr_w1c,
  output logic stall_flag,
  output logic irq
);
  logic run, tick, wrap;

  assign run = tmo_en && !svc_pend;

  tmo_prescale #(.DIV(SLOW_DIV)) u_pre (
    .clk(clk), .rst(rst), .run(run), .slow(slow_sel), .tick(tick)
  );

  tmo_counter #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .wrap(wrap)
  );

  tmo_flag u_flag (
    .clk(clk), .rst(rst), .set_evt(wrap), .clr(clr_w1c), .ie(irq_en),
    .flag(stall_flag), .irq(irq)
  );

  // R8: disabling never sets the flag on its own
  assert_off_no_set_R8: assert property (@(posedge clk) disable iff (rst)
    (!tmo_en && !stall_flag) |=> !stall_flag);
  // R1: reset leaves both outputs low
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!stall_flag && !irq));
endmodule

// File: tb/tb_bus_stall_timer.sv
module tb_bus_stall_timer;
  localparam int CLK_PERIOD = 10;
  localparam int PERIOD = 16384;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst, tmo_en, slow_sel, svc_pend, irq_en, clr_w1c;
  logic stall_flag, irq;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_stall_timer dut (
    .clk(clk), .rst(rst), .tmo_en(tmo_en), .slow_sel(slow_sel),
    .svc_pend(svc_pend), .irq_en(irq_en), .clr_w1c(clr_w1c),
    .stall_flag(stall_flag), .irq(irq)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%b exp=%b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic pulse_clear();
    clr_w1c = 1'b1; step(1); clr_w1c = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; tmo_en = 0; slow_sel = 0; svc_pend = 0; irq_en = 0; clr_w1c = 0;
    step(3); rst = 1'b0; step(1);
    chk("R1 flag", stall_flag, 1'b0);
    chk("R1 irq", irq, 1'b0);
  endtask

  task automatic t_basic();
    irq_en = 1'b1; tmo_en = 1'b1;
    step(PERIOD - 1);
    chk("R2 early", stall_flag, 1'b0);
    step(1);
    chk("R2 set", stall_flag, 1'b1);
    chk("R6 irq on", irq, 1'b1);
    pulse_clear();
    chk("R5 cleared", stall_flag, 1'b0);
    tmo_en = 1'b0; step(1);
  endtask

  task automatic t_svc_gate();
    tmo_en = 1'b1;
    step(10000);
    svc_pend = 1'b1; step(5); svc_pend = 1'b0;
    step(PERIOD - 1);
    chk("R3 restarted", stall_flag, 1'b0);
    step(1);
    chk("R3 set", stall_flag, 1'b1);
    irq_en = 1'b0; step(1);
    chk("R6 irq gated", irq, 1'b0);
    chk("R5 sticky", stall_flag, 1'b1);
    irq_en = 1'b1; step(1);
    chk("R6 irq regrant", irq, 1'b1);
    pulse_clear();
    tmo_en = 1'b0; step(1);
  endtask

  task automatic t_slow();
    slow_sel = 1'b1; tmo_en = 1'b1;
    step(4*PERIOD - 1);
    chk("R4 early", stall_flag, 1'b0);
    step(1);
    chk("R4 set", stall_flag, 1'b1);
    tmo_en = 1'b0; step(20);
    chk("R8 flag kept", stall_flag, 1'b1);
    slow_sel = 1'b0;
    pulse_clear();
    chk("R5 clear after off", stall_flag, 1'b0);
  endtask

  task automatic t_off_and_collide();
    tmo_en = 1'b1; step(10000);
    tmo_en = 1'b0; step(2);
    tmo_en = 1'b1;
    step(PERIOD - 1);
    chk("R8 restarted", stall_flag, 1'b0);
    clr_w1c = 1'b1; step(1); clr_w1c = 1'b0;
    chk("R7 set wins", stall_flag, 1'b1);
    chk("R6 irq with set", irq, 1'b1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_svc_gate();
    t_slow();
    t_off_and_collide();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule